// File: doc/BRIEF.md
# Register hazard scoreboard queue

This block records the optional destination register of every instruction that has left the issue point of a pipeline but has not yet retired. Each record holds a valid bit and a register index. At issue the front end pushes one record per instruction. An instruction with no destination pushes a record whose valid bit is clear, so every in-flight instruction still owns a slot. At retirement the back end pops the oldest record.

Several combinational lookup ports let the issue logic ask, in the same cycle, whether a source operand (or a destination, for a write-after-write check) names a register that an in-flight instruction will still write. A lookup reports a hit only when the query is valid, the record is valid, and both indices are equal.

A mode parameter fixes how a same-cycle pop interacts with lookups. In pipelined mode the record being popped is already hidden from lookups, and a full queue may accept a push in the cycle it pops. In conflict-free mode lookups still see the record being popped, and a full queue refuses every push. The depth is a parameter: one for a two-stage machine, two for a three-stage machine.

Top module: `hazard_sbq`

## Requirements
- R1: While reset is asserted and after it is released, `empty` is 1, `full` is 0, every `hit` bit is 0 and `ins_reject` is 0 until the first push.
- R2: `hit[k]` is 1 in the same cycle exactly when `qry_vld[k]` is 1 and some visible occupied record has its valid bit set and the index equal to `qry_idx[k*IDXW +: IDXW]`. An invalid query, or a record with its valid bit clear, never hits.
- R3: An accepted push appends `{ins_vld, ins_idx}`, including a record with `ins_vld`=0. That record takes a slot and counts towards `full`. `full` and `empty` are registered and reflect the occupancy after the edge.
- R4: A pop removes the oldest record (first in, first out). A later lookup no longer sees it, while younger records stay visible.
- R5: A record pushed in a cycle is not visible to lookups in that same cycle. It becomes visible from the next cycle.
- R6: In pipelined mode (`MODE`=SBQ_PIPELINE), a pop in a cycle hides the oldest record from lookups in that same cycle.
- R7: In conflict-free mode (`MODE`=SBQ_CONFLICT_FREE), lookups in a popping cycle still see the record being popped.
- R8: A push when the queue is full is dropped (except as in R10), `ins_reject` is 1 in that same cycle, and the contents are unchanged.
- R9: A pop when the queue is empty has no effect: the queue stays empty and lookups do not hit.
- R10: In pipelined mode a push together with a pop into a full queue is accepted and `ins_reject` stays 0. In conflict-free mode it is rejected.
- R11: The `NSRC` lookup ports are independent: each reports its own query against the same contents in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ins_en | input | 1 | Push request at issue |
| ins_vld | input | 1 | Pushed record has a destination |
| ins_idx | input | IDXW | Pushed destination index |
| rem_en | input | 1 | Pop request at retirement |
| qry_vld | input | NSRC | Per-port query valid |
| qry_idx | input | NSRC*IDXW | Per-port query index, port k at bits k*IDXW |
| hit | output | NSRC | Per-port match result, combinational |
| full | output | 1 | Queue holds DEPTH records |
| empty | output | 1 | Queue holds no record |
| ins_reject | output | 1 | Push refused this cycle, combinational |

## Verification
`hit` and `ins_reject` are combinational, so they are due in the same cycle as the query or push that causes them. `full`, `empty` and lookup visibility change only after the clock edge that commits a push or pop. The bench drives inputs at the falling edge and compares every output a few nanoseconds later, before the next rising edge. It advances its own record queue only at that rising edge. This way a same-cycle result is always compared with the contents as they stood before the edge, and a registered result with the contents after it. Two instances, one per mode, receive identical stimulus, so the R6/R7 and R10 differences are seen side by side.

// File: rtl/sbq_pkg.sv
package sbq_pkg;
  typedef enum logic {
    SBQ_CONFLICT_FREE = 1'b0,
    SBQ_PIPELINE      = 1'b1
  } sbq_mode_e;
endpackage

// File: rtl/sbq_ctrl.sv
module sbq_ctrl #(
  parameter int unsigned DEPTH = 2,
  parameter sbq_pkg::sbq_mode_e MODE = sbq_pkg::SBQ_PIPELINE,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_en,
  input  logic          rem_en,
  output logic          push,
  output logic          pop,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic          full,
  output logic          empty,
  output logic          ins_reject
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic          full_q, full_d, empty_q, empty_d;

  // a pop into a full queue frees the slot early only in pipelined mode
  always_comb begin
    pop        = rem_en && !empty_q;
    push       = ins_en && (!full_q || ((MODE == sbq_pkg::SBQ_PIPELINE) && pop));
    ins_reject = ins_en && !push;
  end

  always_comb begin
    cnt_d = cnt_q;
    wr_d  = wr_q;
    rd_d  = rd_q;
    if (push) begin
      wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    end
    if (pop) begin
      rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    end
    if (push && !pop) begin
      cnt_d = cnt_q + 1'b1;
    end else if (pop && !push) begin
      cnt_d = cnt_q - 1'b1;
    end
    full_d  = (cnt_d == CW'(DEPTH));
    empty_d = (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      wr_q    <= '0;
      rd_q    <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else if (push || pop) begin
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
      rd_q    <= rd_d;
      full_q  <= full_d;
      empty_q <= empty_d;
    end
  end

  assign wr_ptr = wr_q;
  assign rd_ptr = rd_q;
  assign full   = full_q;
  assign empty  = empty_q;
endmodule

// File: rtl/sbq_store.sv
module sbq_store #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned IDXW  = 5,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  logic                  pop,
  input  logic [PW-1:0]         wr_ptr,
  input  logic [PW-1:0]         rd_ptr,
  input  logic                  in_vld,
  input  logic [IDXW-1:0]       in_idx,
  output logic [DEPTH-1:0]      live,
  output logic [DEPTH-1:0]      ent_vld,
  output logic [DEPTH*IDXW-1:0] ent_idx
);
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic            wr_here, rd_here;
    logic            live_q, live_d;
    logic            vld_q;
    logic [IDXW-1:0] idx_q;

    always_comb begin
      wr_here = push && (wr_ptr == PW'(s));
      rd_here = pop && (rd_ptr == PW'(s));
      live_d  = live_q;
      if (rd_here) live_d = 1'b0;
      if (wr_here) live_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q <= 1'b0;
      end else if (wr_here || rd_here) begin
        live_q <= live_d;
      end
    end

    // payload is qualified by live_q, so it needs no reset
    always_ff @(posedge clk) begin
      if (wr_here) begin
        vld_q <= in_vld;
        idx_q <= in_idx;
      end
    end

    assign live[s]                  = live_q;
    assign ent_vld[s]               = vld_q;
    assign ent_idx[s*IDXW +: IDXW]  = idx_q;
  end
endmodule

// File: rtl/sbq_search.sv
module sbq_search #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned IDXW  = 5,
  parameter int unsigned NSRC  = 3
) (
  input  logic [DEPTH-1:0]      vis,
  input  logic [DEPTH-1:0]      ent_vld,
  input  logic [DEPTH*IDXW-1:0] ent_idx,
  input  logic [NSRC-1:0]       qry_vld,
  input  logic [NSRC*IDXW-1:0]  qry_idx,
  output logic [NSRC-1:0]       hit
);
  for (genvar k = 0; k < NSRC; k++) begin : g_port
    logic [DEPTH-1:0] slot_hit;
    always_comb begin
      for (int s = 0; s < DEPTH; s++) begin
        slot_hit[s] = vis[s] && ent_vld[s] &&
                      (ent_idx[s*IDXW +: IDXW] == qry_idx[k*IDXW +: IDXW]);
      end
    end
    assign hit[k] = qry_vld[k] && (|slot_hit);
  end
endmodule

// File: rtl/hazard_sbq.sv
module hazard_sbq #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned IDXW  = 5,
  parameter int unsigned NSRC  = 3,
  parameter sbq_pkg::sbq_mode_e MODE = sbq_pkg::SBQ_PIPELINE,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ins_en,
  input  logic                 ins_vld,
  input  logic [IDXW-1:0]      ins_idx,
  input  logic                 rem_en,
  input  logic [NSRC-1:0]      qry_vld,
  input  logic [NSRC*IDXW-1:0] qry_idx,
  output logic [NSRC-1:0]      hit,
  output logic                 full,
  output logic                 empty,
  output logic                 ins_reject
);
  logic                  push, pop;
  logic [PW-1:0]         wr_ptr, rd_ptr;
  logic [DEPTH-1:0]      live, vis, ent_vld;
  logic [DEPTH*IDXW-1:0] ent_idx;
  logic                  hide_oldest;

  sbq_ctrl #(.DEPTH(DEPTH), .MODE(MODE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .rem_en(rem_en),
    .push(push), .pop(pop), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .full(full), .empty(empty), .ins_reject(ins_reject)
  );

  sbq_store #(.DEPTH(DEPTH), .IDXW(IDXW)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .in_vld(ins_vld), .in_idx(ins_idx),
    .live(live), .ent_vld(ent_vld), .ent_idx(ent_idx)
  );

  // pipelined mode: the record retiring this cycle is already gone for lookups
  assign hide_oldest = (MODE == sbq_pkg::SBQ_PIPELINE) && pop;

  for (genvar s = 0; s < DEPTH; s++) begin : g_vis
    assign vis[s] = live[s] && !(hide_oldest && (rd_ptr == PW'(s)));
  end

  sbq_search #(.DEPTH(DEPTH), .IDXW(IDXW), .NSRC(NSRC)) u_search (
    .vis(vis), .ent_vld(ent_vld), .ent_idx(ent_idx),
    .qry_vld(qry_vld), .qry_idx(qry_idx), .hit(hit)
  );
endmodule

// File: rtl/sbq_chk.sv
module sbq_chk #(
  parameter int unsigned NSRC = 3,
  parameter sbq_pkg::sbq_mode_e MODE = sbq_pkg::SBQ_PIPELINE
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ins_en,
  input logic            rem_en,
  input logic [NSRC-1:0] qry_vld,
  input logic [NSRC-1:0] hit,
  input logic            full,
  input logic            empty,
  input logic            ins_reject
);
  // R2: an invalid query never reports a hit
  assert_no_invalid_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & ~qry_vld) == '0);

  // R9: nothing can match in an empty queue
  assert_empty_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (hit == '0));

  // R9: a lone pop on an empty queue leaves it empty
  assert_pop_empty_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rem_en && !ins_en) |=> empty);

  // R3: an accepted push leaves the queue non-empty
  assert_push_fills_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && !rem_en && !full) |=> !empty);

  // R3: occupancy flags are never both set
  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R8: a refused push only happens on a full queue, which then stays full
  assert_reject_only_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ins_reject |-> full);
  assert_reject_keeps_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_reject && !rem_en) |=> full);

  // R10: pipelined mode accepts a push alongside a pop into a full queue
  assert_pipe_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((MODE == sbq_pkg::SBQ_PIPELINE) && full && rem_en && ins_en) |-> !ins_reject);
endmodule

bind hazard_sbq sbq_chk #(.NSRC(NSRC), .MODE(MODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .rem_en(rem_en),
  .qry_vld(qry_vld), .hit(hit), .full(full), .empty(empty),
  .ins_reject(ins_reject)
);

// File: tb/sim_hazard_sbq.sv
module sim_hazard_sbq;
  localparam int D  = 2;
  localparam int IW = 3;
  localparam int NS = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic ins_en, ins_vld, rem_en;
  logic [IW-1:0]    ins_idx;
  logic [NS-1:0]    qv;
  logic [NS*IW-1:0] qi;
  logic [NS-1:0] hit0, hit1;
  logic full0, full1, empty0, empty1, rej0, rej1;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // record = {valid, index}; queue 0 models pipelined mode, queue 1 conflict-free
  logic [IW:0] mq0[$];
  logic [IW:0] mq1[$];

  always #4 clk = ~clk;

  hazard_sbq #(.DEPTH(D), .IDXW(IW), .NSRC(NS), .MODE(sbq_pkg::SBQ_PIPELINE)) u0 (
    .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .ins_vld(ins_vld), .ins_idx(ins_idx),
    .rem_en(rem_en), .qry_vld(qv), .qry_idx(qi), .hit(hit0), .full(full0),
    .empty(empty0), .ins_reject(rej0));

  hazard_sbq #(.DEPTH(D), .IDXW(IW), .NSRC(NS), .MODE(sbq_pkg::SBQ_CONFLICT_FREE)) u1 (
    .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .ins_vld(ins_vld), .ins_idx(ins_idx),
    .rem_en(rem_en), .qry_vld(qv), .qry_idx(qi), .hit(hit1), .full(full1),
    .empty(empty1), .ins_reject(rej1));

  task automatic check_one(input string tag, input string what, input logic [NS-1:0] act,
                           input logic [NS-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%b exp=%b", tag, what, act, exp);
    end
  endtask

  task automatic check_inst(input string tag, input string nm, ref logic [IW:0] q[$],
                            input bit pipe, input logic [NS-1:0] h,
                            input logic f, input logic e, input logic r);
    logic [NS-1:0] eh;
    bit pop, push;
    pop  = rem_en && (q.size() > 0);
    push = ins_en && ((q.size() < D) || (pipe && pop));
    eh = '0;
    for (int k = 0; k < NS; k++) begin
      for (int j = 0; j < q.size(); j++) begin
        if (!(pipe && pop && j == 0) && qv[k] && q[j][IW] && (q[j][IW-1:0] == qi[k*IW +: IW]))
          eh[k] = 1'b1;
      end
    end
    check_one(tag, {nm, " hit"}, h, eh);
    check_one(tag, {nm, " full"}, {{(NS-1){1'b0}}, f}, {{(NS-1){1'b0}}, q.size() == D});
    check_one(tag, {nm, " empty"}, {{(NS-1){1'b0}}, e}, {{(NS-1){1'b0}}, q.size() == 0});
    check_one(tag, {nm, " reject"}, {{(NS-1){1'b0}}, r}, {{(NS-1){1'b0}}, ins_en && !push});
  endtask

  task automatic update(ref logic [IW:0] q[$], input bit pipe);
    bit pop, push;
    pop  = rem_en && (q.size() > 0);
    push = ins_en && ((q.size() < D) || (pipe && pop));
    if (pop)  void'(q.pop_front());
    if (push) q.push_back({ins_vld, ins_idx});
  endtask

  // inputs are set at the falling edge; compare 2 ns later, commit at the rising edge
  task automatic step(input string tag);
    #2;
    check_inst(tag, "u0", mq0, 1'b1, hit0, full0, empty0, rej0);
    check_inst(tag, "u1", mq1, 1'b0, hit1, full1, empty1, rej1);
    @(posedge clk);
    update(mq0, 1'b1);
    update(mq1, 1'b0);
    @(negedge clk);
  endtask

  task automatic drive(input bit ie, input bit iv, input int ix, input bit re);
    ins_en = ie; ins_vld = iv; ins_idx = IW'(ix); rem_en = re;
  endtask

  task automatic query(input int k, input bit v, input int ix);
    qv[k] = v;
    qi[k*IW +: IW] = IW'(ix);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(0, 0, 0, 0);
    qv = '1; qi = '0;
    repeat (3) @(negedge clk);
    // R1: reset state with queries active
    #2;
    check_inst("R1", "u0", mq0, 1'b1, hit0, full0, empty0, rej0);
    check_inst("R1", "u1", mq1, 1'b0, hit1, full1, empty1, rej1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    qv = '0;
    step("R1");

    // R5: push of r3 is not yet visible in its own cycle
    drive(1, 1, 3, 0); query(0, 1, 3);
    step("R5");
    // R2: visible now; invalid query with same index does not hit
    drive(0, 0, 0, 0); query(0, 1, 3); query(1, 0, 3); query(2, 1, 4);
    step("R2");
    // R3: push a record with no destination, index 4; it must not hit query r4
    drive(1, 0, 4, 0);
    step("R3");
    drive(0, 0, 0, 0); query(0, 1, 4); query(1, 1, 3); query(2, 0, 0);
    step("R3");
    // R8: push into full queue without pop is refused
    drive(1, 1, 6, 0); query(0, 1, 6);
    step("R8");
    drive(0, 0, 0, 0); query(0, 1, 6);
    step("R8");
    // R6/R7 and R10: pop r3 while searching r3 and pushing r5 into a full queue
    drive(1, 1, 5, 1); query(0, 1, 3); query(1, 1, 5); query(2, 0, 0);
    step("R6");
    drive(0, 0, 0, 0); query(0, 1, 3); query(1, 1, 5);
    step("R10");
    drive(0, 0, 0, 1);
    step("R7");
    // R4: drain, then push r1,r2 and pop one; r1 gone, r2 remains
    drive(0, 0, 0, 1);
    step("R4");
    // R9: pop on empty
    drive(0, 0, 0, 1); query(0, 1, 5);
    step("R9");
    drive(1, 1, 1, 0); query(0, 0, 0); query(1, 0, 0);
    step("R4");
    drive(1, 1, 2, 0);
    step("R4");
    drive(0, 0, 0, 1);
    step("R4");
    drive(0, 0, 0, 0); query(0, 1, 1); query(1, 1, 2); query(2, 1, 2);
    step("R4");
    // R11: three ports, three different queries
    query(0, 1, 2); query(1, 1, 7); query(2, 0, 2);
    step("R11");

    // R2: random traffic compared every cycle in both modes
    for (int n = 0; n < 3000; n++) begin
      drive($urandom_range(0, 1), $urandom_range(0, 3) != 0, $urandom_range(0, 7),
            $urandom_range(0, 2) == 0);
      for (int k = 0; k < NS; k++) query(k, $urandom_range(0, 3) != 0, $urandom_range(0, 7));
      step("R2");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule